// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the stack pointer of a small 8-bit processor whose stack grows from high addresses toward low ones. Each cycle it takes one operation code: idle, single-byte push, single-byte pop, call (any kind of subroutine or interrupt entry that saves a two-byte return address) or return (plain or from interrupt). It moves the pointer by one or two bytes. It also presents, one cycle later, the data-memory byte addresses at which the stack bytes of that operation are written or read. The memory and the data values stay outside the block.

Software reads and writes the pointer as two byte-wide registers, a low byte and a high byte. Only the lower twelve pointer bits are implemented, and all arithmetic wraps inside them. After reset the pointer addresses the last location of internal data memory.

Top module: `stkp_top`

## Requirements
- R1: While reset is high, and after it, the pointer equals 0x4FF (low register 0xFF, high register 0x04) until the first operation or write, and all access outputs are zero.
- R2: Op code 1 (push) lowers the pointer by 1. The next cycle shows acc_en=1, acc_we=1, acc_pair=0 and acc_addr_a equal to the pointer value before the push.
- R3: Op code 2 (pop) raises the pointer by 1. The next cycle shows acc_en=1, acc_we=0, acc_pair=0 and acc_addr_a equal to the new pointer value, so a pop reads back the byte written by the matching push.
- R4: Op code 3 (call) lowers the pointer by 2. The next cycle shows acc_en=1, acc_we=1, acc_pair=1, acc_addr_a (low return byte) equal to the old pointer and acc_addr_b (high return byte) equal to the old pointer minus 1.
- R5: Op code 4 (return) raises the pointer by 2. The next cycle shows acc_en=1, acc_we=0, acc_pair=1, acc_addr_b equal to the old pointer plus 1 and acc_addr_a equal to the old pointer plus 2.
- R6: With op idle and sw_we=1, sw_hi=0 loads sw_wdata into pointer bits 7:0, and sw_hi=1 loads sw_wdata bits 3:0 into pointer bits 11:8. The change is visible after the next clock edge.
- R7: Bits 7:4 of the high register always read zero. The write data bits that fall on them are dropped.
- R8: When an operation and a software write arrive in the same cycle, the operation updates the pointer and the write is discarded.
- R9: Pointer and access-address arithmetic wraps modulo 4096.
- R10: Op codes 0, 5, 6 and 7 are idle. They leave the pointer unchanged and produce no access.
- R11: Access outputs are registered. In the cycle after an idle op, acc_en, acc_we, acc_pair, acc_addr_a and acc_addr_b are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Stack operation code: 0 idle, 1 push, 2 pop, 3 call, 4 return, others idle |
| sw_we_i | input | 1 | Software write strobe for one pointer byte |
| sw_hi_i | input | 1 | Byte select for software write: 0 low, 1 high |
| sw_wdata_i | input | 8 | Software write data |
| sp_lo_o | output | 8 | Low pointer byte as read by software |
| sp_hi_o | output | 8 | High pointer byte as read by software, bits 7:4 zero |
| acc_en_o | output | 1 | A stack memory access belongs to the previous cycle's operation |
| acc_we_o | output | 1 | Access is a write (push or call) |
| acc_pair_o | output | 1 | Access covers two bytes (call or return) |
| acc_addr_a_o | output | 12 | Address of the single byte, or of the low return-address byte |
| acc_addr_b_o | output | 12 | Address of the high return-address byte, zero for one-byte accesses |

## Verification
The bench drives runs of pushes followed by pops, and nested calls followed by returns. A queue of written addresses shows whether each read address is the exact mirror of its write. Mixed orders, such as a pop right after a call, separate the pre-increment from the post-decrement convention. Pointer loads near zero and near 0xFFF, followed by calls and returns, expose missing wrap-around. Same-cycle operation and write, writes that set the unused high bits, and the unused op codes separate the priority and masking rules from plain arithmetic.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [2:0] {
    STK_IDLE = 3'd0,
    STK_PUSH = 3'd1,
    STK_POP  = 3'd2,
    STK_CALL = 3'd3,
    STK_RET  = 3'd4
  } stk_op_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = 16;
endpackage

// File: rtl/stkp_arith.sv
module stkp_arith
  import stkp_pkg::*;
#(
  parameter int unsigned PTR_W = 12
) (
  input  logic [2:0]       op_i,
  input  logic [PTR_W-1:0] sp_i,
  output logic             act_o,
  output logic [PTR_W-1:0] nxt_sp_o,
  output logic             en_o,
  output logic             we_o,
  output logic             pair_o,
  output logic [PTR_W-1:0] addr_a_o,
  output logic [PTR_W-1:0] addr_b_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  always_comb begin
    act_o    = 1'b0;
    nxt_sp_o = sp_i;
    en_o     = 1'b0;
    we_o     = 1'b0;
    pair_o   = 1'b0;
    addr_a_o = '0;
    addr_b_o = '0;
    case (op_i)
      STK_PUSH: begin
        act_o    = 1'b1;
        en_o     = 1'b1;
        we_o     = 1'b1;
        addr_a_o = sp_i;
        nxt_sp_o = sp_i - ONE;
      end
      STK_POP: begin
        act_o    = 1'b1;
        en_o     = 1'b1;
        addr_a_o = sp_i + ONE;
        nxt_sp_o = sp_i + ONE;
      end
      STK_CALL: begin
        act_o    = 1'b1;
        en_o     = 1'b1;
        we_o     = 1'b1;
        pair_o   = 1'b1;
        addr_a_o = sp_i;
        addr_b_o = sp_i - ONE;
        nxt_sp_o = sp_i - TWO;
      end
      STK_RET: begin
        act_o    = 1'b1;
        en_o     = 1'b1;
        pair_o   = 1'b1;
        addr_b_o = sp_i + ONE;
        addr_a_o = sp_i + TWO;
        nxt_sp_o = sp_i + TWO;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stkp_ptr_reg.sv
module stkp_ptr_reg #(
  parameter int unsigned        PTR_W   = 12,
  parameter logic [PTR_W-1:0]   RST_VAL = 12'h4FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic [PTR_W-1:0] nxt_sp_i,
  input  logic             sw_we_i,
  input  logic             sw_hi_i,
  input  logic [7:0]       sw_wdata_i,
  output logic [PTR_W-1:0] sp_o
);
  localparam int unsigned HI_W = PTR_W - 8;

  logic [PTR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= RST_VAL;
    end else if (act_i) begin
      sp_q <= nxt_sp_i;
    end else if (sw_we_i) begin
      if (sw_hi_i) sp_q[PTR_W-1:8] <= sw_wdata_i[HI_W-1:0];
      else         sp_q[7:0]       <= sw_wdata_i;
    end
  end

  assign sp_o = sp_q;

  // R8
  op_over_write_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i && sw_we_i) |=> (sp_q == $past(nxt_sp_i)));
endmodule

// File: rtl/stkp_acc_reg.sv
module stkp_acc_reg #(
  parameter int unsigned PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             pair_i,
  input  logic [PTR_W-1:0] addr_a_i,
  input  logic [PTR_W-1:0] addr_b_i,
  output logic             en_o,
  output logic             we_o,
  output logic             pair_o,
  output logic [PTR_W-1:0] addr_a_o,
  output logic [PTR_W-1:0] addr_b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= 1'b0;
      we_o     <= 1'b0;
      pair_o   <= 1'b0;
      addr_a_o <= '0;
      addr_b_o <= '0;
    end else begin
      en_o     <= en_i;
      we_o     <= we_i;
      pair_o   <= pair_i;
      addr_a_o <= addr_a_i;
      addr_b_o <= addr_b_i;
    end
  end

  // R11
  write_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (we_o || pair_o) |-> en_o);
endmodule

// File: rtl/stkp_top.sv
module stkp_top
  import stkp_pkg::*;
#(
  parameter int unsigned      PTR_W   = 12,
  parameter logic [PTR_W-1:0] RST_VAL = 12'h4FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic             sw_we_i,
  input  logic             sw_hi_i,
  input  logic [7:0]       sw_wdata_i,
  output logic [7:0]       sp_lo_o,
  output logic [7:0]       sp_hi_o,
  output logic             acc_en_o,
  output logic             acc_we_o,
  output logic             acc_pair_o,
  output logic [PTR_W-1:0] acc_addr_a_o,
  output logic [PTR_W-1:0] acc_addr_b_o
);
  localparam int unsigned PAD_W = REG_W - PTR_W;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] nxt_sp;
  logic             act;
  logic             c_en, c_we, c_pair;
  logic [PTR_W-1:0] c_addr_a, c_addr_b;

  stkp_arith #(.PTR_W(PTR_W)) arith_i (
    .op_i     (op_i),
    .sp_i     (sp),
    .act_o    (act),
    .nxt_sp_o (nxt_sp),
    .en_o     (c_en),
    .we_o     (c_we),
    .pair_o   (c_pair),
    .addr_a_o (c_addr_a),
    .addr_b_o (c_addr_b)
  );

  stkp_ptr_reg #(.PTR_W(PTR_W), .RST_VAL(RST_VAL)) ptr_i (
    .clk        (clk),
    .rst        (rst),
    .act_i      (act),
    .nxt_sp_i   (nxt_sp),
    .sw_we_i    (sw_we_i),
    .sw_hi_i    (sw_hi_i),
    .sw_wdata_i (sw_wdata_i),
    .sp_o       (sp)
  );

  stkp_acc_reg #(.PTR_W(PTR_W)) acc_i (
    .clk      (clk),
    .rst      (rst),
    .en_i     (c_en),
    .we_i     (c_we),
    .pair_i   (c_pair),
    .addr_a_i (c_addr_a),
    .addr_b_i (c_addr_b),
    .en_o     (acc_en_o),
    .we_o     (acc_we_o),
    .pair_o   (acc_pair_o),
    .addr_a_o (acc_addr_a_o),
    .addr_b_o (acc_addr_b_o)
  );

  assign sp_lo_o = sp[7:0];
  assign sp_hi_o = {{PAD_W{1'b0}}, sp[PTR_W-1:8]};

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_PUSH) |=> (sp == $past(sp) - ONE) && acc_we_o && !acc_pair_o
                           && (acc_addr_a_o == $past(sp)));
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_POP) |=> (sp == $past(sp) + ONE) && acc_en_o && !acc_we_o
                          && (acc_addr_a_o == sp));
  // R4
  call_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_CALL) |=> (sp == $past(sp) - TWO) && acc_pair_o && acc_we_o
                           && (acc_addr_b_o == sp + ONE));
  // R5
  ret_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_RET) |=> (sp == $past(sp) + TWO) && acc_pair_o && !acc_we_o
                          && (acc_addr_a_o == sp));
  // R6
  sw_low_load_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i == STK_IDLE) && sw_we_i && !sw_hi_i) |=> (sp_lo_o == $past(sw_wdata_i)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i > 3'd4) && !sw_we_i) |=> $stable(sp) && !acc_en_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_IDLE) |=> !acc_en_o && (acc_addr_a_o == '0) && (acc_addr_b_o == '0));
endmodule

// File: tb/stkp_top_tb_top.sv
module stkp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = 12'hFFF;
  localparam int RSTV = 12'h4FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = 3'd0;
  logic        sw_we_i = 1'b0;
  logic        sw_hi_i = 1'b0;
  logic [7:0]  sw_wdata_i = 8'd0;
  logic [7:0]  sp_lo_o, sp_hi_o;
  logic        acc_en_o, acc_we_o, acc_pair_o;
  logic [11:0] acc_addr_a_o, acc_addr_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_sp = RSTV;
  int wq[$];
  int e_en, e_we, e_pair, e_a, e_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  stkp_top dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .sw_we_i(sw_we_i), .sw_hi_i(sw_hi_i),
    .sw_wdata_i(sw_wdata_i), .sp_lo_o(sp_lo_o), .sp_hi_o(sp_hi_o),
    .acc_en_o(acc_en_o), .acc_we_o(acc_we_o), .acc_pair_o(acc_pair_o),
    .acc_addr_a_o(acc_addr_a_o), .acc_addr_b_o(acc_addr_b_o)
  );

  task automatic cyc(input bit r, input int op, input bit we, input bit hi,
                     input int wd, input string tag);
    rst = r; op_i = 3'(op); sw_we_i = we; sw_hi_i = hi; sw_wdata_i = 8'(wd);
    e_en = 0; e_we = 0; e_pair = 0; e_a = 0; e_b = 0;
    if (r) begin
      m_sp = RSTV; wq.delete();
    end else if (op == 1) begin
      e_en = 1; e_we = 1; e_a = m_sp; wq.push_back(m_sp);
      m_sp = (m_sp - 1) & MASK;
    end else if (op == 2) begin
      m_sp = (m_sp + 1) & MASK; e_en = 1;
      e_a = (wq.size() > 0) ? wq.pop_back() : m_sp;
    end else if (op == 3) begin
      e_en = 1; e_we = 1; e_pair = 1; e_a = m_sp; e_b = (m_sp - 1) & MASK;
      wq.push_back(e_a); wq.push_back(e_b);
      m_sp = (m_sp - 2) & MASK;
    end else if (op == 4) begin
      e_en = 1; e_pair = 1;
      e_b = (wq.size() > 0) ? wq.pop_back() : ((m_sp + 1) & MASK);
      e_a = (wq.size() > 0) ? wq.pop_back() : ((m_sp + 2) & MASK);
      m_sp = (m_sp + 2) & MASK;
    end else if (we) begin
      wq.delete();
      if (hi) m_sp = (m_sp & 8'hFF) | ((wd & 4'hF) << 8);
      else    m_sp = (m_sp & 12'hF00) | (wd & 8'hFF);
    end
    @(negedge clk);
    checks++;
    if (sp_lo_o !== 8'(m_sp & 8'hFF) || sp_hi_o !== 8'(m_sp >> 8) ||
        acc_en_o !== 1'(e_en) || acc_we_o !== 1'(e_we) || acc_pair_o !== 1'(e_pair) ||
        acc_addr_a_o !== 12'(e_a) || acc_addr_b_o !== 12'(e_b)) begin
      failures++;
      $display("FAIL %s: actual sp=%02h%02h en=%0d we=%0d pair=%0d a=%03h b=%03h expected sp=%03h en=%0d we=%0d pair=%0d a=%03h b=%03h",
               tag, sp_hi_o, sp_lo_o, acc_en_o, acc_we_o, acc_pair_o, acc_addr_a_o,
               acc_addr_b_o, m_sp, e_en, e_we, e_pair, e_a, e_b);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, 0, 0, 0, "R1 reset");
    cyc(1, 1, 1, 0, 8'h12, "R1 reset ignores inputs");
    cyc(0, 0, 0, 0, 0, "R1 after reset");
    cyc(0, 0, 0, 0, 0, "R11 idle quiet");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R2 push");
    for (int i = 0; i < 3; i++) cyc(0, 2, 0, 0, 0, "R3 pop");
    cyc(0, 3, 0, 0, 0, "R4 call");
    cyc(0, 3, 0, 0, 0, "R4 nested call");
    cyc(0, 1, 0, 0, 0, "R2 push in frame");
    cyc(0, 2, 0, 0, 0, "R3 pop in frame");
    cyc(0, 4, 0, 0, 0, "R5 return");
    cyc(0, 4, 0, 0, 0, "R5 outer return");
    cyc(0, 3, 0, 0, 0, "R4 call then pop");
    cyc(0, 2, 0, 0, 0, "R3 pop after call");
    cyc(0, 2, 0, 0, 0, "R3 second pop after call");
    for (int c = 5; c < 8; c++) cyc(0, c, 0, 0, 0, "R10 unused code");
    cyc(0, 0, 0, 0, 0, "R11 idle after unused");
    cyc(0, 0, 1, 0, 8'h3C, "R6 low write");
    cyc(0, 0, 1, 1, 8'h02, "R6 high write");
    cyc(0, 0, 1, 1, 8'hF7, "R7 high upper bits dropped");
    cyc(0, 0, 0, 0, 0, "R7 high reads zero");
    cyc(0, 1, 1, 0, 8'h00, "R8 push beats low write");
    cyc(0, 4, 1, 1, 8'h0A, "R8 return beats high write");
    cyc(0, 0, 1, 1, 8'h00, "R9 set high zero");
    cyc(0, 0, 1, 0, 8'h00, "R9 set low zero");
    cyc(0, 1, 0, 0, 0, "R9 push wraps below zero");
    cyc(0, 2, 0, 0, 0, "R9 pop wraps above top");
    cyc(0, 0, 1, 0, 8'h01, "R9 set one");
    cyc(0, 3, 0, 0, 0, "R9 call wraps");
    cyc(0, 4, 0, 0, 0, "R9 return wraps");
    cyc(0, 0, 1, 1, 8'h0F, "R9 set high F");
    cyc(0, 0, 1, 0, 8'hFE, "R9 set FFE");
    cyc(0, 4, 0, 0, 0, "R9 return from FFE");
    cyc(0, 3, 0, 0, 0, "R9 call from 000");
    cyc(1, 0, 0, 0, 0, "R1 reset mid run");
    cyc(0, 0, 0, 0, 0, "R1 value after second reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule